// File: doc/BRIEF.md
# Profiling Event Counter Unit

This block gathers run-time profiling figures for a processor core. It keeps one wide cycle counter and five narrow event counters, each fed by a strobe from the core. The five counters cover extra instruction cycles, exception overhead cycles, sleep cycles, extra load/store cycles and zero-cycle (folded) instructions. Software reads and presets all of them through a simple word-addressed register port. A control word turns the cycle counter on and stores two further feature enables. Its top byte reports fixed capability flags and a comparator count.

After reset the register port is locked. Every write is ignored except a write to the key register. Writing the unlock key value opens the port. Writing any other value to the key register locks it again. A read-only status register shows whether the port is locked.

Register word addresses on `reg_addr`:

| Address | Register |
|---|---|
| 0 | control |
| 1 | cycle count |
| 2 | extra instruction cycles |
| 3 | exception overhead |
| 4 | sleep cycles |
| 5 | load/store extra cycles |
| 6 | folded instructions |
| 7 | key, write-only |
| 8 | lock status |

Top module: `perf_cnt_unit`

## Requirements
- R1: After reset the port is locked, every counter reads 0, and control bits 0, 12 and 16 read 0. The control word reads 0x4C000000 with default parameters: no-profiling flag 0 at bit 24, no-cycle flag 0 at bit 25, no-external-match flag 1 at bit 26, no-trace flag 1 at bit 27, and comparator count 4 in bits 31:28.
- R2: While locked, writes to every address other than 7 leave all register contents unchanged, and the lock status register (address 8) reads 1.
- R3: Writing 0xC5ACCE55 to address 7 unlocks the port, and the status then reads 0. Writing any other value to address 7 locks it again.
- R4: When unlocked, only control bits 0 (cycle counter enable), 12 (sample enable) and 16 (exception trace enable) are writable. All other written bits are ignored, and bits 31:24 always show the capability parameters.
- R5: The cycle counter adds 1 on each clock on which control bit 0 and the `trace_en` input are both high. Otherwise it holds its value.
- R6: An unlocked write to address 1 presets the cycle counter, and a write to addresses 2 to 6 presets that event counter from data bits 7:0. A preset wins over an increment in the same cycle.
- R7: The extra-instruction counter adds 1 per cycle with `ev_cpi` high, except in cycles where `ev_lsu` is also high.
- R8: The exception, sleep, load/store and fold counters each add 1 per cycle that their strobe is high.
- R9: The event counters are 8 bits wide and wrap from 255 to 0.
- R10: Event counters read zero-extended, address 7 reads 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| trace_en | input | 1 | Global trace enable that gates the cycle counter |
| ev_cpi | input | 1 | Extra instruction-cycle strobe |
| ev_exc | input | 1 | Exception overhead cycle strobe |
| ev_sleep | input | 1 | Sleeping cycle strobe |
| ev_lsu | input | 1 | Extra load/store cycle strobe |
| ev_fold | input | 1 | Folded instruction strobe |

## Verification
The strobes are driven alone, in pairs where the load/store strobe overlaps the instruction-cycle strobe, and for runs long enough to wrap a counter. These runs separate the exclusion rule from plain counting and show that the counters wrap rather than saturate. The cycle counter is run with each of its two gating conditions low in turn, which shows that both are required. Writes are attempted before unlocking, after a wrong key, and together with a strobe in the same cycle. These cases separate the lock gating from the priority of a preset over an increment.

// File: rtl/perf_cnt_pkg.sv
package perf_cnt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int NUM_EVT = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CYC   = 4'd1;
  localparam logic [ADDR_W-1:0] A_EVT0  = 4'd2;
  localparam logic [ADDR_W-1:0] A_KEY   = 4'd7;
  localparam logic [ADDR_W-1:0] A_LSTAT = 4'd8;

  localparam int EV_CPI   = 0;
  localparam int EV_EXC   = 1;
  localparam int EV_SLEEP = 2;
  localparam int EV_LSU   = 3;
  localparam int EV_FOLD  = 4;

  localparam int B_CYC_EN  = 0;
  localparam int B_SAMP_EN = 12;
  localparam int B_EXC_EN  = 16;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;

  typedef struct packed {
    logic exc_en;
    logic samp_en;
    logic cyc_en;
  } ctrl_t;
endpackage

// File: rtl/perf_lock_ctl.sv
module perf_lock_ctl
  import perf_cnt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              locked
);
  logic lock_q, lock_d;

  always_comb begin
    lock_d = lock_q;
    if (key_wr) lock_d = (key_data != UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_q <= 1'b1;
    else if (key_wr) lock_q <= lock_d;
  end

  assign locked = lock_q;

  // R3
  unlock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data == UNLOCK_KEY) |=> !locked);
  // R3
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data != UNLOCK_KEY) |=> locked);
endmodule

// File: rtl/perf_event_ctr.sv
module perf_event_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | inc;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R9
  evt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && cnt == {W{1'b1}}) |=> cnt == '0);
  // R6
  evt_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  // R8
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !load) |=> $stable(cnt));
endmodule

// File: rtl/perf_cycle_ctr.sv
module perf_cycle_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | run;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R5
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt));
  // R5
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> cnt != $past(cnt));
endmodule

// File: rtl/perf_cnt_unit.sv
module perf_cnt_unit
  import perf_cnt_pkg::*;
#(
  parameter int         CYC_W    = 32,
  parameter int         EVT_W    = 8,
  parameter int         NUM_CMP  = 4,
  parameter logic       NO_PRF   = 1'b0,
  parameter logic       NO_CYC   = 1'b0,
  parameter logic       NO_EXT   = 1'b1,
  parameter logic       NO_TRC   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              trace_en,
  input  logic              ev_cpi,
  input  logic              ev_exc,
  input  logic              ev_sleep,
  input  logic              ev_lsu,
  input  logic              ev_fold
);
  localparam logic [7:0] CAP_BYTE = {4'(NUM_CMP), NO_TRC, NO_EXT, NO_CYC, NO_PRF};

  logic locked;
  logic wr_ok;
  logic key_wr;

  assign key_wr = reg_wr && (reg_addr == A_KEY);
  assign wr_ok  = reg_wr && !locked;

  perf_lock_ctl u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (reg_wdata),
    .locked   (locked)
  );

  // control register
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_we;

  assign ctrl_we = wr_ok && (reg_addr == A_CTRL);

  always_comb begin
    ctrl_d.cyc_en  = reg_wdata[B_CYC_EN];
    ctrl_d.samp_en = reg_wdata[B_SAMP_EN];
    ctrl_d.exc_en  = reg_wdata[B_EXC_EN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  // cycle counter
  logic             cyc_load;
  logic [CYC_W-1:0] cyc_cnt;

  assign cyc_load = wr_ok && (reg_addr == A_CYC);

  perf_cycle_ctr #(.W(CYC_W)) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cyc_load),
    .load_val (reg_wdata[CYC_W-1:0]),
    .run      (ctrl_q.cyc_en && trace_en),
    .cnt      (cyc_cnt)
  );

  // event counters
  logic [NUM_EVT-1:0] evt_inc;
  logic [NUM_EVT-1:0] evt_load;
  logic [EVT_W-1:0]   evt_cnt [NUM_EVT];

  always_comb begin
    evt_inc          = '0;
    evt_inc[EV_CPI]  = ev_cpi & ~ev_lsu;
    evt_inc[EV_EXC]  = ev_exc;
    evt_inc[EV_SLEEP]= ev_sleep;
    evt_inc[EV_LSU]  = ev_lsu;
    evt_inc[EV_FOLD] = ev_fold;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    assign evt_load[i] = wr_ok && (reg_addr == A_EVT0 + ADDR_W'(i));
    perf_event_ctr #(.W(EVT_W)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (evt_load[i]),
      .load_val (reg_wdata[EVT_W-1:0]),
      .inc      (evt_inc[i]),
      .cnt      (evt_cnt[i])
    );
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[31:24]     = CAP_BYTE;
      reg_rdata[B_CYC_EN]  = ctrl_q.cyc_en;
      reg_rdata[B_SAMP_EN] = ctrl_q.samp_en;
      reg_rdata[B_EXC_EN]  = ctrl_q.exc_en;
    end else if (reg_addr == A_CYC) begin
      reg_rdata = DATA_W'(cyc_cnt);
    end else if (reg_addr == A_LSTAT) begin
      reg_rdata[0] = locked;
    end else begin
      for (int k = 0; k < NUM_EVT; k++)
        if (reg_addr == A_EVT0 + ADDR_W'(k)) reg_rdata = DATA_W'(evt_cnt[k]);
    end
  end

  // R2
  locked_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && reg_wr) |=> $stable(ctrl_q) && $stable(cyc_cnt) || trace_en);
  // R7
  cpi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_lsu && !evt_load[EV_CPI]) |=> $stable(evt_cnt[EV_CPI]));
  // R4
  cap_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> reg_rdata[31:24] == CAP_BYTE);
endmodule

// File: tb/test_perf_cnt_unit.sv
`timescale 1ns/1ps
module test_perf_cnt_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        trace_en;
  logic        ev_cpi, ev_exc, ev_sleep, ev_lsu, ev_fold;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  perf_cnt_unit i_perf_cnt_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trace_en(trace_en),
    .ev_cpi(ev_cpi), .ev_exc(ev_exc), .ev_sleep(ev_sleep),
    .ev_lsu(ev_lsu), .ev_fold(ev_fold)
  );

  // monitor: compares read data with the expected item a little after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (reg_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, reg_rdata, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_wr   = 1'b0;
    reg_addr = a;
    sb_q.push_back('{e, tag});
    @(posedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  // drive strobes {cpi,exc,sleep,lsu,fold} for n clock edges
  task automatic pulse(input logic [4:0] s, input int n);
    @(negedge clk);
    {ev_cpi, ev_exc, ev_sleep, ev_lsu, ev_fold} = s;
    repeat (n) @(posedge clk);
    #1 {ev_cpi, ev_exc, ev_sleep, ev_lsu, ev_fold} = '0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; trace_en = 1'b0;
    {ev_cpi, ev_exc, ev_sleep, ev_lsu, ev_fold} = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, 32'h4C00_0000, "R1 ctrl");
    rd(4'd1, 32'h0, "R1 cycle");
    rd(4'd6, 32'h0, "R1 fold");
    rd(4'd8, 32'h1, "R1/R2 lock status");

    // R2 locked writes ignored
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd3, 32'h0000_0055);
    rd(4'd0, 32'h4C00_0000, "R2 ctrl locked");
    rd(4'd3, 32'h0, "R2 exc locked");

    // R3 unlock
    wr(4'd7, 32'hC5AC_CE55);
    rd(4'd8, 32'h0, "R3 unlocked");
    rd(4'd7, 32'h0, "R10 key reads 0");

    // R4 control writable bits
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, 32'h4C01_1001, "R4 ctrl all ones");
    wr(4'd0, 32'h0000_1000);
    rd(4'd0, 32'h4C00_1000, "R4 ctrl sample only");

    // R5 gating: bit0 clear, trace high
    wr(4'd1, 32'd100);
    @(negedge clk); trace_en = 1'b1;
    repeat (5) @(posedge clk);
    #1 trace_en = 1'b0;
    rd(4'd1, 32'd100, "R5 hold bit0 clear");
    // bit0 set, trace low
    wr(4'd0, 32'h0000_0001);
    repeat (4) @(posedge clk);
    rd(4'd1, 32'd100, "R5 hold trace low");
    // both high for 10 edges
    @(negedge clk); trace_en = 1'b1;
    repeat (10) @(posedge clk);
    #1 trace_en = 1'b0;
    rd(4'd1, 32'd110, "R5/R6 count 10");

    // R8 single strobes
    pulse(5'b01000, 3);
    rd(4'd3, 32'd3, "R8 exc");
    pulse(5'b00100, 7);
    rd(4'd4, 32'd7, "R8 sleep");
    pulse(5'b00001, 2);
    rd(4'd6, 32'd2, "R8 fold");

    // R7 exclusion
    pulse(5'b10000, 4);
    rd(4'd2, 32'd4, "R7 cpi alone");
    pulse(5'b10010, 5);
    rd(4'd2, 32'd4, "R7 cpi masked by lsu");
    rd(4'd5, 32'd5, "R8 lsu");

    // R9 wrap
    wr(4'd5, 32'h0000_01FD);
    rd(4'd5, 32'h0000_00FD, "R6/R10 preset low byte");
    pulse(5'b00010, 3);
    rd(4'd5, 32'h0, "R9 wrap 253+3");

    // R6 preset wins over increment
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd6; reg_wdata = 32'h40; ev_fold = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0; ev_fold = 1'b0;
    rd(4'd6, 32'h40, "R6 preset beats increment");

    // R10 unmapped
    rd(4'd12, 32'h0, "R10 unmapped");

    // R3 relock
    wr(4'd7, 32'h0000_1234);
    rd(4'd8, 32'h1, "R3 relock status");
    wr(4'd0, 32'h0001_0000);
    rd(4'd0, 32'h4C00_0001, "R2 ctrl after relock");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule